// File: doc/BRIEF.md
# Converter Host Bus Configuration Port

This block is the host side of an 8-bit parallel data converter. A processor reaches it over a shared 8-bit data bus with an active-low chip select, an active-low write strobe and an active-low read strobe. It holds two 6-bit setting registers. Which register a write reaches is chosen by the top two bits of the written byte. The decoded settings go to the conversion sequencer: the start source, the status style, the clock source, power-down, and the output coding.

All strobes and the bus are sampled on the block clock. Edges are found by comparing each sampled value with the one from the cycle before. A completed write sets the addressed register. When software start is active, the same write also sends a one-cycle start request to the sequencer. A read drives the latest conversion result onto the bus, in straight binary or two's complement. A board that ties the write strobe low can still bring the block to a known all-zero setup by issuing a single read.

The block drives data-out and an output-enable for the pad buffers. It never drives the pads itself.

Top module: `pbus_cfg_top`

## Requirements
- R1: A write event is a rising edge of wr_n, as sampled on clk, while cs_n is sampled low. One clock after the edge is detected, the addressed register holds bits 5..0 of the byte sampled with that edge. A wr_n edge while cs_n is high changes nothing.
- R2: Bits 7..6 of the written byte are the register address: 00 selects register 0 and 01 selects register 1.
- R3: Register 0 fields are exported as follows. Bit 5 is cfg_sw_start (1 = software start). Bit 4 is cfg_eoc_mode (1 = end-of-conversion level, 0 = interrupt pulse). Bit 3 is cfg_ext_clk (1 = external clock). Bit 2 is cfg_pwrdn (1 = power-down request).
- R4: Register 1 bit 1 is exported as cfg_twos (1 = two's-complement output, 0 = straight binary).
- R5: A write with address 10 or 11 leaves both registers unchanged.
- R6: A rising edge of rd_n loads zero into both registers when cs_n is low and wr_n has been low for the current and the previous sample. A read that ends while wr_n is high leaves the registers unchanged.
- R7: bus_oe is high exactly when the previous clock sampled both cs_n and rd_n low. It is low otherwise.
- R8: bus_out equals conv_result when cfg_twos is 0, and equals conv_result with bit 7 inverted when cfg_twos is 1.
- R9: sw_start_req pulses high for one cycle, in the same cycle the register update takes effect, for each write event (of any address) while cfg_sw_start is 1 before that write. It is low otherwise.
- R10: After reset, all cfg outputs, bus_oe and sw_start_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, acts on its rising edge |
| rd_n | input | 1 | Read strobe, active low |
| bus_in | input | 8 | Data arriving from the host bus pads |
| conv_result | input | 8 | Latest unipolar conversion result |
| bus_out | output | 8 | Data toward the host bus pads |
| bus_oe | output | 1 | Pad output enable |
| cfg_sw_start | output | 1 | Software start selected |
| cfg_eoc_mode | output | 1 | End-of-conversion level status selected |
| cfg_ext_clk | output | 1 | External clock selected |
| cfg_pwrdn | output | 1 | Software power-down requested |
| cfg_twos | output | 1 | Two's-complement output coding selected |
| sw_start_req | output | 1 | One-cycle sampling start request |

## Verification
The assertions assume that strobes, chip select and bus data are already synchronous to clk. They also assume the written byte is stable on the edge where wr_n is sampled rising, and that wr_n and rd_n are never low together except in the tied-low default sequence. The stimulus changes every input only on the falling clock edge. It holds the data byte for the whole write, and it releases one strobe before asserting the other.

// File: rtl/pbus_cfg_pkg.sv
package pbus_cfg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = DATA_W - ADDR_W;

  // field positions inside the control part of each register
  localparam int R0_SWSTART = 5;
  localparam int R0_EOC     = 4;
  localparam int R0_EXTCLK  = 3;
  localparam int R0_PWRDN   = 2;
  localparam int R1_TWOS    = 1;

  typedef struct packed {
    logic sw_start;
    logic eoc_mode;
    logic ext_clk;
    logic pwrdn;
    logic twos;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [CTRL_W-1:0] r0,
                                      input logic [CTRL_W-1:0] r1);
    cfg_t c;
    c.sw_start = r0[R0_SWSTART];
    c.eoc_mode = r0[R0_EOC];
    c.ext_clk  = r0[R0_EXTCLK];
    c.pwrdn    = r0[R0_PWRDN];
    c.twos     = r1[R1_TWOS];
    return c;
  endfunction

  // offset-binary to two's complement: flip the sign position
  function automatic logic [DATA_W-1:0] apply_coding(input logic [DATA_W-1:0] raw,
                                                     input logic twos);
    logic [DATA_W-1:0] v;
    v = raw;
    if (twos) v[DATA_W-1] = ~raw[DATA_W-1];
    return v;
  endfunction
endpackage

// File: rtl/pbus_strobe_sync.sv
module pbus_strobe_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prev,
  output logic [N-1:0] rise
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      logic s_q, d_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_q <= RST_VAL[i];
          d_q <= RST_VAL[i];
        end else begin
          s_q <= raw[i];
          d_q <= s_q;
        end
      end
      assign lvl[i]  = s_q;
      assign prev[i] = d_q;
      assign rise[i] = s_q & ~d_q;
    end
  endgenerate
endmodule

// File: rtl/pbus_cfg_regs.sv
module pbus_cfg_regs
  import pbus_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic              hw_def_ev,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTRL_W-1:0] reg0,
  output logic [CTRL_W-1:0] reg1,
  output logic              sw_start_req
);
  localparam int NREG = 2;

  logic [ADDR_W-1:0] addr;
  logic [NREG-1:0]   sel;
  logic [CTRL_W-1:0] regs_q [NREG];

  assign addr = wdata[DATA_W-1 -: ADDR_W];

  genvar k;
  generate
    for (k = 0; k < NREG; k++) begin : g_reg
      assign sel[k] = wr_ev && (addr == ADDR_W'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          regs_q[k] <= '0;
        else if (hw_def_ev)  regs_q[k] <= '0;
        else if (sel[k])     regs_q[k] <= wdata[CTRL_W-1:0];
      end
    end
  endgenerate

  assign reg0 = regs_q[0];
  assign reg1 = regs_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_start_req <= 1'b0;
    else        sw_start_req <= wr_ev && regs_q[0][R0_SWSTART];
  end

  assert_wr_reg0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && wdata[DATA_W-1 -: ADDR_W] == 2'b00) |=> (reg0 == $past(wdata[CTRL_W-1:0])));
  assert_wr_reg1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && wdata[DATA_W-1 -: ADDR_W] == 2'b01) |=> (reg1 == $past(wdata[CTRL_W-1:0])));
  assert_bad_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && wdata[DATA_W-1]) |=> ($stable(reg0) && $stable(reg1)));
  assert_hw_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_def_ev |=> (reg0 == '0 && reg1 == '0));
  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && reg0[R0_SWSTART]) |=> sw_start_req);
  assert_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> !sw_start_req);
endmodule

// File: rtl/pbus_rd_fmt.sv
module pbus_rd_fmt
  import pbus_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] raw,
  input  logic              twos,
  input  logic              rd_active,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  assign bus_out = apply_coding(raw, twos);
  assign bus_oe  = rd_active;

  assert_coding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    twos |-> (bus_out[DATA_W-1] != raw[DATA_W-1] &&
              bus_out[DATA_W-2:0] == raw[DATA_W-2:0]));
  assert_binary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !twos |-> (bus_out == raw));
endmodule

// File: rtl/pbus_cfg_top.sv
module pbus_cfg_top
  import pbus_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [DATA_W-1:0] conv_result,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              cfg_sw_start,
  output logic              cfg_eoc_mode,
  output logic              cfg_ext_clk,
  output logic              cfg_pwrdn,
  output logic              cfg_twos,
  output logic              sw_start_req
);
  localparam int NSTB = 3;
  localparam int I_CS = 2;
  localparam int I_WR = 1;
  localparam int I_RD = 0;

  logic [NSTB-1:0]   stb_lvl, stb_prev, stb_rise;
  logic [DATA_W-1:0] data_q;
  logic [CTRL_W-1:0] reg0, reg1;
  logic              cs_act, wr_ev, wr_held_low, hw_def_ev, rd_active;
  cfg_t              cfg;

  pbus_strobe_sync #(.N(NSTB), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({cs_n, wr_n, rd_n}),
    .lvl  (stb_lvl),
    .prev (stb_prev),
    .rise (stb_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= bus_in;
  end

  // named events for the register bank and the checks
  assign cs_act      = ~stb_lvl[I_CS];
  assign wr_ev       = stb_rise[I_WR] & cs_act;
  assign wr_held_low = ~stb_lvl[I_WR] & ~stb_prev[I_WR];
  assign hw_def_ev   = stb_rise[I_RD] & cs_act & wr_held_low;
  assign rd_active   = cs_act & ~stb_lvl[I_RD];

  pbus_cfg_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ev       (wr_ev),
    .hw_def_ev   (hw_def_ev),
    .wdata       (data_q),
    .reg0        (reg0),
    .reg1        (reg1),
    .sw_start_req(sw_start_req)
  );

  assign cfg          = decode_cfg(reg0, reg1);
  assign cfg_sw_start = cfg.sw_start;
  assign cfg_eoc_mode = cfg.eoc_mode;
  assign cfg_ext_clk  = cfg.ext_clk;
  assign cfg_pwrdn    = cfg.pwrdn;
  assign cfg_twos     = cfg.twos;

  pbus_rd_fmt u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (conv_result),
    .twos     (cfg.twos),
    .rd_active(rd_active),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe)
  );

  assert_oe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) || $past(rd_n)) |-> !bus_oe);
  assert_oe_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cs_n) && !$past(rd_n)) |-> bus_oe);
  assert_cs_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |=> ($stable(cfg_sw_start) && $stable(cfg_eoc_mode) &&
                     $stable(cfg_ext_clk) && $stable(cfg_pwrdn) && $stable(cfg_twos)));
endmodule

// File: tb/pbus_cfg_top_test.sv
module pbus_cfg_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] bus_in = 8'h00, conv_result = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe, cfg_sw_start, cfg_eoc_mode, cfg_ext_clk, cfg_pwrdn, cfg_twos, sw_start_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       req;
    logic [14:0] mask;
    logic [14:0] exp;
  } item_t;
  item_t sb_q[$];
  event  check_ev;

  always #2 clk = ~clk;

  pbus_cfg_top uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .bus_in(bus_in), .conv_result(conv_result), .bus_out(bus_out), .bus_oe(bus_oe),
    .cfg_sw_start(cfg_sw_start), .cfg_eoc_mode(cfg_eoc_mode), .cfg_ext_clk(cfg_ext_clk),
    .cfg_pwrdn(cfg_pwrdn), .cfg_twos(cfg_twos), .sw_start_req(sw_start_req)
  );

  // observed word: start, oe, data[7:0], sw, eoc, ext, pwrdn, twos
  function automatic logic [14:0] observe();
    return {sw_start_req, bus_oe, bus_out, cfg_sw_start, cfg_eoc_mode,
            cfg_ext_clk, cfg_pwrdn, cfg_twos};
  endfunction

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(check_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [14:0] got;
        it  = sb_q.pop_front();
        got = observe();
        checks++;
        if ((got & it.mask) !== (it.exp & it.mask)) begin
          errors++;
          $display("FAIL %s: got %h expected %h (mask %h)", it.req, got & it.mask,
                   it.exp & it.mask, it.mask);
        end
      end
    end
  end

  task automatic push(input string req, input logic [14:0] mask, input logic [14:0] exp);
    item_t it;
    it.req = req; it.mask = mask; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic expect_cfg(input string req, input logic s, e, c, p, t);
    push(req, 15'h001F, {10'b0, s, e, c, p, t});
  endtask
  task automatic expect_start(input string req, input logic v);
    push(req, 15'h4000, {v, 14'b0});
  endtask
  task automatic expect_oe(input string req, input logic v);
    push(req, 15'h2000, {1'b0, v, 13'b0});
  endtask
  task automatic expect_data(input string req, input logic [7:0] d);
    push(req, 15'h1FE0, {2'b0, d, 5'b0});
  endtask
  task automatic fire();
    -> check_ev;
    #0;
  endtask

  // expected coding written independently: XOR with the sign weight
  function automatic logic [7:0] coded(input logic [7:0] r, input logic t);
    return t ? (r ^ 8'h80) : r;
  endfunction

  // after return we sit at the negedge following the register update
  task automatic do_write(input logic [7:0] w, input logic cs);
    @(negedge clk);
    cs_n = cs; bus_in = w; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic release_bus();
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    expect_cfg("R10", 0, 0, 0, 0, 0);
    expect_oe("R10", 0);
    expect_start("R10", 0);
    fire();

    // R1 R3: register 0 = sw start, ext clk, power-down
    do_write(8'b00_101100, 1'b0);
    expect_cfg("R1 R3", 1, 0, 1, 1, 0);
    expect_start("R9 first write", 0);
    fire();
    release_bus();

    // R2 R4: register 1 twos; start pulse since sw start is active
    do_write(8'b01_000010, 1'b0);
    expect_cfg("R2 R4", 1, 0, 1, 1, 1);
    expect_start("R9 pulse", 1);
    fire();
    release_bus();
    expect_start("R9 one cycle", 0);
    fire();

    // R5: addresses 10 and 11 ignored
    do_write(8'b10_111111, 1'b0);
    expect_cfg("R5 addr10", 1, 0, 1, 1, 1);
    fire();
    release_bus();
    do_write(8'b11_000000, 1'b0);
    expect_cfg("R5 addr11", 1, 0, 1, 1, 1);
    fire();
    release_bus();

    // R1: chip select high, write ignored
    do_write(8'b00_000000, 1'b1);
    expect_cfg("R1 cs high", 1, 0, 1, 1, 1);
    expect_start("R9 cs high", 0);
    fire();

    // R7 R8: reads in two's complement
    foreach (bus_in[i]) begin end
    for (int n = 0; n < 3; n++) begin
      logic [7:0] r;
      r = (n == 0) ? 8'h3C : (n == 1) ? 8'h80 : 8'hFF;
      @(negedge clk);
      conv_result = r; cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      expect_oe("R7 read", 1);
      expect_data("R8 twos", coded(r, 1'b1));
      fire();
      rd_n = 1'b1;
      @(negedge clk);
      expect_oe("R7 release", 0);
      expect_cfg("R6 normal read", 1, 0, 1, 1, 1);
      fire();
      cs_n = 1'b1;
    end

    // R7: read strobe with chip select high
    @(negedge clk);
    rd_n = 1'b0;
    @(negedge clk);
    expect_oe("R7 cs high", 0);
    fire();
    rd_n = 1'b1;

    // R8: back to binary
    do_write(8'b01_000000, 1'b0);
    release_bus();
    @(negedge clk);
    conv_result = 8'hA5; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    expect_data("R8 binary", coded(8'hA5, 1'b0));
    expect_cfg("R4 binary", 1, 0, 1, 1, 0);
    fire();
    rd_n = 1'b1; cs_n = 1'b1;

    // R9: turning off sw start pulses once more, then stops
    do_write(8'b00_010000, 1'b0);
    expect_cfg("R3 eoc", 0, 1, 0, 0, 0);
    expect_start("R9 prior value", 1);
    fire();
    release_bus();
    do_write(8'b00_011000, 1'b0);
    expect_start("R9 hw start", 0);
    expect_cfg("R3 ext clk", 0, 1, 1, 0, 0);
    fire();
    release_bus();
    do_write(8'b01_000010, 1'b0);
    release_bus();

    // R6: write tied low, dummy read clears both registers
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expect_cfg("R6 default", 0, 0, 0, 0, 0);
    fire();
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule